// File: doc/BRIEF.md
# Disk Controller Transfer Buffer with Threshold Request

This block is the byte buffer that a floppy disk controller places between its disk-side data path and the host during a data-moving command. Bytes from the disk are pushed in and popped by the host on reads. On writes the host pushes bytes and the disk side pops them. The block raises one service request toward the host whenever the host should move data. The request may be wired to a DMA request or an interrupt line.

When the buffer is enabled and the command is in its execution phase, the buffer holds up to sixteen bytes. The request follows a programmable 4-bit threshold. In every other situation the block acts as a single-byte holding stage with a zero threshold. Those situations are the command and result phases, a disabled buffer, and a transfer direction that has been turned off. The request can run in burst fashion, where it stays high until the buffer is drained or filled. It can also run in paced fashion, where it is forced low for a fixed number of clock cycles after every host-side byte.

A hardware reset clears all settings. A software reset clears the contents and the error flags. It also clears the enable and the threshold, unless the lock setting is on.

Top module: `fdc_xfer_fifo`

## Requirements
- R1: In execution phase (phase code 1) with the buffer enabled and the active direction not turned off, the buffer holds up to DEPTH (16) bytes, returns them in push order, and reports full exactly at DEPTH.
- R2: In command phase (code 0) or result phase (code 2), and whenever the buffer is not enabled, the effective capacity is one byte and the effective threshold is zero.
- R3: After hardware reset (rst_n low), the buffer is disabled, the threshold is 0, lock is off, paced mode is selected, neither direction is turned off, the level is 0, empty is 1, both error flags are 0, and the request is low while empty in read direction.
- R4: A software reset empties the buffer and clears both error flags. It returns the enable and the threshold to disabled and 0 when lock is off, and keeps both when lock is on.
- R5: With dir_rd=1 (disk to host), the request condition is level >= threshold+1. With dir_rd=0 (host to disk), the condition is free space >= threshold+1, where free space is the effective capacity minus the level.
- R6: mode_rd_off=1 makes a read-direction transfer in execution phase behave as in R2, and mode_wr_off=1 does the same for the write direction.
- R7: In burst mode (mode_burst=1), once the request is high it stays high until the buffer is empty (read) or full (write), even when the threshold condition no longer holds.
- R8: In paced mode (mode_burst=0), each accepted host-side byte forces the request low for exactly GAP_CYC clock cycles after the transfer edge. A host-side byte is a pop in read direction and a push in write direction.
- R9: A push while full sets a sticky overrun flag and drops the byte. A pop while empty sets a sticky underrun flag and leaves the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| sw_rst | input | 1 | Software reset pulse |
| cfg_we | input | 1 | Load enable and threshold |
| cfg_fifo_en | input | 1 | Buffer enable value |
| cfg_thresh | input | TW | Threshold value |
| mode_we | input | 1 | Load mode settings |
| mode_rd_off | input | 1 | Turn buffer off for reads |
| mode_wr_off | input | 1 | Turn buffer off for writes |
| mode_burst | input | 1 | 1 = burst request, 0 = paced |
| lock_we | input | 1 | Load lock setting |
| lock_set | input | 1 | Lock value |
| phase | input | 2 | 0 command, 1 execution, 2 result |
| dir_rd | input | 1 | 1 = disk to host, 0 = host to disk |
| push | input | 1 | Write strobe |
| push_data | input | DW | Byte written |
| pop | input | 1 | Read strobe |
| pop_data | output | DW | Byte at the head |
| req | output | 1 | Service request to host |
| level | output | log2(DEPTH)+1 | Bytes held |
| empty | output | 1 | Level is zero |
| full | output | 1 | Level reached effective capacity |
| overrun | output | 1 | Sticky push-while-full flag |
| underrun | output | 1 | Sticky pop-while-empty flag |

## Verification
The bench builds the block with DEPTH 16, TW 4 and GAP_CYC 3. With these values the top threshold of 15 equals a completely full buffer, so both ends of the threshold range can be reached. The short gap keeps the paced-mode low window brief enough to check cycle by cycle, including the exact cycle in which the request comes back. A scoreboard queue follows the expected byte order through the bypass, read and write directions, so dropped and reordered bytes show up as mismatches.

// File: rtl/fdc_fifo_pkg.sv
package fdc_fifo_pkg;
   typedef enum logic [1:0] {
      PH_CMD    = 2'd0,
      PH_EXEC   = 2'd1,
      PH_RESULT = 2'd2
   } phase_e;

   typedef struct packed {
      logic rd_off;
      logic wr_off;
      logic burst;
   } mode_t;
endpackage

// File: rtl/fdc_fifo_cfg.sv
module fdc_fifo_cfg
   import fdc_fifo_pkg::*;
#(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_rst,
   input  logic          cfg_we,
   input  logic          cfg_en,
   input  logic [TW-1:0] cfg_th,
   input  logic          mode_we,
   input  mode_t         mode_in,
   input  logic          lock_we,
   input  logic          lock_in,
   output logic          fifo_en,
   output logic [TW-1:0] thresh,
   output mode_t         mode,
   output logic          lock
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_en <= 1'b0;
         thresh  <= '0;
         lock    <= 1'b0;
      end else if (sw_rst) begin
         if (!lock) begin
            fifo_en <= 1'b0;
            thresh  <= '0;
         end
      end else begin
         if (cfg_we) begin
            fifo_en <= cfg_en;
            thresh  <= cfg_th;
         end
         if (lock_we) lock <= lock_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode <= '0;
      else if (mode_we) mode <= mode_in;
   end

   AST_SWRST_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_rst && !lock) |=> (!fifo_en && thresh == '0)); // R4
   AST_SWRST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_rst && lock) |=> ($stable(fifo_en) && $stable(thresh))); // R4
endmodule

// File: rtl/fdc_fifo_store.sv
module fdc_fifo_store #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_rst,
   input  logic [CW-1:0] cap,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic [CW-1:0] level,
   output logic          empty,
   output logic          full,
   output logic          overrun,
   output logic          underrun
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          wr_ok, rd_ok;

   assign empty = (level == '0);
   assign full  = (level >= cap);
   assign wr_ok = push && !full;
   assign rd_ok = pop && !empty;
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         level    <= '0;
         overrun  <= 1'b0;
         underrun <= 1'b0;
      end else if (sw_rst) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         level    <= '0;
         overrun  <= 1'b0;
         underrun <= 1'b0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
         if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
         if (push && full)  overrun  <= 1'b1;
         if (pop && empty)  underrun <= 1'b1;
      end
   end

   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH)); // R1
   AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !sw_rst) |=> overrun); // R9
   AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> (level == '0)); // R9
endmodule

// File: rtl/fdc_fifo_reqgen.sv
module fdc_fifo_reqgen #(
   parameter int CW      = 5,
   parameter int TW      = 4,
   parameter int GAP_CYC = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sw_rst,
   input  logic          dir_rd,
   input  logic          burst,
   input  logic          host_xfer,
   input  logic [CW-1:0] level,
   input  logic [CW-1:0] cap,
   input  logic [TW-1:0] eff_th,
   output logic          req
);
   logic [CW-1:0] free_w, th_p1;
   logic          raw, drained, hold_q, gap_zero;

   assign free_w  = (level >= cap) ? '0 : (cap - level);
   assign th_p1   = {{(CW-TW){1'b0}}, eff_th} + 1'b1;
   assign raw     = dir_rd ? (level >= th_p1) : (free_w >= th_p1);
   assign drained = dir_rd ? (level == '0) : (free_w == '0);

   always_comb begin
      if (burst) req = (raw || hold_q) && !drained;
      else       req = raw && gap_zero;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hold_q <= 1'b0;
      else if (sw_rst) hold_q <= 1'b0;
      else             hold_q <= burst && req;
   end

   generate
      if (GAP_CYC > 0) begin : g_gap
         localparam int GW = $clog2(GAP_CYC + 1);
         logic [GW-1:0] gap_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  gap_cnt <= '0;
            else if (sw_rst)             gap_cnt <= '0;
            else if (host_xfer && !burst) gap_cnt <= GW'(GAP_CYC);
            else if (gap_cnt != '0)      gap_cnt <= gap_cnt - 1'b1;
         end
         assign gap_zero = (gap_cnt == '0);

         AST_GAP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (!burst && host_xfer && !sw_rst) |=> (!req || burst)); // R8
      end else begin : g_nogap
         assign gap_zero = 1'b1;
      end
   endgenerate

   AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (burst && req && !sw_rst) |=> (req || !burst || drained)); // R7
endmodule

// File: rtl/fdc_xfer_fifo.sv
module fdc_xfer_fifo
   import fdc_fifo_pkg::*;
#(
   parameter int DEPTH   = 16,
   parameter int DW      = 8,
   parameter int TW      = 4,
   parameter int GAP_CYC = 18
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sw_rst,
   input  logic                     cfg_we,
   input  logic                     cfg_fifo_en,
   input  logic [TW-1:0]            cfg_thresh,
   input  logic                     mode_we,
   input  logic                     mode_rd_off,
   input  logic                     mode_wr_off,
   input  logic                     mode_burst,
   input  logic                     lock_we,
   input  logic                     lock_set,
   input  logic [1:0]               phase,
   input  logic                     dir_rd,
   input  logic                     push,
   input  logic [DW-1:0]            push_data,
   input  logic                     pop,
   output logic [DW-1:0]            pop_data,
   output logic                     req,
   output logic [$clog2(DEPTH):0]   level,
   output logic                     empty,
   output logic                     full,
   output logic                     overrun,
   output logic                     underrun
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2)
         $error("DEPTH must be a power of two of at least 2");
      if (TW > AW)
         $error("threshold range exceeds buffer depth");
      if (DW < 1)
         $error("DW must be positive");
   endgenerate

   logic          fifo_en, lock;
   logic [TW-1:0] thresh, eff_th;
   mode_t         mode, mode_in;
   logic          active, host_xfer;
   logic [CW-1:0] cap;

   assign mode_in = '{rd_off: mode_rd_off, wr_off: mode_wr_off, burst: mode_burst};

   fdc_fifo_cfg #(.TW(TW)) cfg_i (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
      .cfg_we(cfg_we), .cfg_en(cfg_fifo_en), .cfg_th(cfg_thresh),
      .mode_we(mode_we), .mode_in(mode_in),
      .lock_we(lock_we), .lock_in(lock_set),
      .fifo_en(fifo_en), .thresh(thresh), .mode(mode), .lock(lock)
   );

   assign active = (phase == PH_EXEC) && fifo_en &&
                   (dir_rd ? !mode.rd_off : !mode.wr_off);
   assign cap    = active ? CW'(DEPTH) : CW'(1);
   assign eff_th = active ? thresh : '0;

   fdc_fifo_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cap(cap),
      .push(push), .din(push_data), .pop(pop), .dout(pop_data),
      .level(level), .empty(empty), .full(full),
      .overrun(overrun), .underrun(underrun)
   );

   assign host_xfer = dir_rd ? (pop && !empty) : (push && !full);

   fdc_fifo_reqgen #(.CW(CW), .TW(TW), .GAP_CYC(GAP_CYC)) req_i (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
      .dir_rd(dir_rd), .burst(mode.burst), .host_xfer(host_xfer),
      .level(level), .cap(cap), .eff_th(eff_th), .req(req)
   );

   AST_BYPASS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && push && !pop && !sw_rst && level != '0) |=> $stable(level)); // R2
   AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_rst && !lock_we) |=> $stable(lock)); // R4
endmodule

// File: tb/fdc_xfer_fifo_tb_top.sv
module fdc_xfer_fifo_tb_top;
   localparam int DEPTH = 16;
   localparam int DW    = 8;
   localparam int TW    = 4;
   localparam int GAP   = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sw_rst = 1'b0;
   logic          cfg_we = 1'b0, cfg_fifo_en = 1'b0;
   logic [TW-1:0] cfg_thresh = '0;
   logic          mode_we = 1'b0, mode_rd_off = 1'b0, mode_wr_off = 1'b0, mode_burst = 1'b0;
   logic          lock_we = 1'b0, lock_set = 1'b0;
   logic [1:0]    phase = 2'd0;
   logic          dir_rd = 1'b1;
   logic          push = 1'b0, pop = 1'b0;
   logic [DW-1:0] push_data = '0;
   logic [DW-1:0] pop_data;
   logic          req, empty, full, overrun, underrun;
   logic [4:0]    level;

   int n_chk = 0;
   int n_bad = 0;
   logic [DW-1:0] exp_q[$];
   logic [DW-1:0] seed = 8'h21;

   always #10 clk = ~clk;

   fdc_xfer_fifo #(.DEPTH(DEPTH), .DW(DW), .TW(TW), .GAP_CYC(GAP)) dut_i (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
      .cfg_we(cfg_we), .cfg_fifo_en(cfg_fifo_en), .cfg_thresh(cfg_thresh),
      .mode_we(mode_we), .mode_rd_off(mode_rd_off), .mode_wr_off(mode_wr_off),
      .mode_burst(mode_burst), .lock_we(lock_we), .lock_set(lock_set),
      .phase(phase), .dir_rd(dir_rd), .push(push), .push_data(push_data),
      .pop(pop), .pop_data(pop_data), .req(req), .level(level),
      .empty(empty), .full(full), .overrun(overrun), .underrun(underrun)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // monitor: compares every byte the design hands out against the queue
   always @(posedge clk) begin
      if (rst_n && !sw_rst && pop && exp_q.size() > 0) begin
         logic [DW-1:0] e;
         e = exp_q.pop_front();
         n_chk++;
         if (pop_data !== e) begin
            n_bad++;
            $display("FAIL R1 order: actual %0h expected %0h", pop_data, e);
         end
      end
   end

   task automatic do_push(input bit accept);
      @(negedge clk);
      seed = seed * 8'd5 + 8'd3;
      push = 1'b1;
      push_data = seed;
      if (accept) exp_q.push_back(seed);
      @(negedge clk);
      push = 1'b0;
   endtask

   task automatic do_pop();
      @(negedge clk);
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
   endtask

   task automatic do_cfg(input bit en, input int th);
      @(negedge clk);
      cfg_we = 1'b1; cfg_fifo_en = en; cfg_thresh = TW'(th);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_mode(input bit rd_off, input bit wr_off, input bit burst);
      @(negedge clk);
      mode_we = 1'b1; mode_rd_off = rd_off; mode_wr_off = wr_off; mode_burst = burst;
      @(negedge clk);
      mode_we = 1'b0;
   endtask

   task automatic do_lock(input bit v);
      @(negedge clk);
      lock_we = 1'b1; lock_set = v;
      @(negedge clk);
      lock_we = 1'b0;
   endtask

   task automatic do_swrst();
      @(negedge clk);
      sw_rst = 1'b1;
      @(negedge clk);
      sw_rst = 1'b0;
      exp_q.delete();
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R3 reset state
      chk("R3 level", level, 0);
      chk("R3 empty", empty, 1);
      chk("R3 overrun", overrun, 0);
      chk("R3 underrun", underrun, 0);
      chk("R3 req", req, 0);

      // R2 command phase: one byte at a time, threshold zero
      do_push(1);
      chk("R2 level", level, 1);
      chk("R2 full", full, 1);
      chk("R2 req", req, 1);
      do_push(0);
      chk("R9 overrun", overrun, 1);
      chk("R9 dropped", level, 1);
      do_pop();
      chk("R2 drained", level, 0);
      do_swrst();
      chk("R4 flags clear", overrun, 0);

      // R1 full depth, threshold 15
      phase = 2'd1;
      do_cfg(1, 15);
      for (int i = 0; i < 15; i++) do_push(1);
      chk("R5 below th", req, 0);
      chk("R1 not full", full, 0);
      do_push(1);
      chk("R1 level", level, 16);
      chk("R1 full", full, 1);
      chk("R5 at th", req, 1);
      for (int i = 0; i < 16; i++) do_pop();
      chk("R1 empty", empty, 1);
      do_pop();
      chk("R9 underrun", underrun, 1);
      chk("R9 level held", level, 0);
      do_swrst();

      // R5 read threshold 3
      do_cfg(1, 3);
      for (int i = 0; i < 3; i++) do_push(1);
      chk("R5 rd 3 bytes", req, 0);
      do_push(1);
      chk("R5 rd 4 bytes", req, 1);
      // R8 paced gap with threshold 0
      do_cfg(1, 0);
      do_pop();
      chk("R8 gap c1", req, 0);
      idle(1);
      chk("R8 gap c2", req, 0);
      idle(1);
      chk("R8 gap c3", req, 0);
      idle(1);
      chk("R8 gap end", req, 1);
      for (int i = 0; i < 3; i++) do_pop();
      chk("R8 drained", req, 0);

      // R7 burst mode
      do_cfg(1, 3);
      do_mode(0, 0, 1);
      for (int i = 0; i < 4; i++) do_push(1);
      chk("R7 start", req, 1);
      do_pop();
      chk("R7 hold 3", req, 1);
      do_pop();
      do_pop();
      chk("R7 hold 1", req, 1);
      do_pop();
      chk("R7 release", req, 0);
      do_mode(0, 0, 0);

      // R5 write direction threshold 5
      dir_rd = 1'b0;
      do_cfg(1, 5);
      idle(1);
      chk("R5 wr empty", req, 1);
      for (int i = 0; i < 10; i++) do_push(1);
      idle(GAP + 1);
      chk("R5 wr free 6", req, 1);
      do_push(1);
      idle(GAP + 1);
      chk("R5 wr free 5", req, 0);
      for (int i = 0; i < 11; i++) do_pop();
      chk("R5 wr drained", level, 0);
      dir_rd = 1'b1;

      // R6 read direction turned off
      do_mode(1, 0, 0);
      do_push(1);
      chk("R6 cap one", full, 1);
      chk("R6 th zero", req, 1);
      do_push(0);
      chk("R6 overrun", overrun, 1);
      do_swrst();
      do_mode(0, 0, 0);

      // R4 lock keeps configuration
      do_cfg(1, 7);
      do_lock(1);
      do_swrst();
      for (int i = 0; i < 7; i++) do_push(1);
      chk("R4 locked th", req, 0);
      do_push(1);
      chk("R4 locked 8", req, 1);
      chk("R4 locked level", level, 8);
      do_lock(0);
      do_swrst();
      chk("R4 sw cleared", level, 0);
      do_push(1);
      chk("R4 unlocked cap", full, 1);
      do_pop();

      // R3 hardware reset disables
      do_cfg(1, 7);
      @(negedge clk);
      rst_n = 1'b0;
      exp_q.delete();
      @(negedge clk);
      rst_n = 1'b1;
      chk("R3 hw level", level, 0);
      do_push(1);
      chk("R3 hw disabled", full, 1);
      do_pop();
      idle(2);
      report();
   end
endmodule